// File: doc/BRIEF.md
# PHY Power-Up Sequencer

This block brings a multi-lane serial PHY out of reset in a fixed order for the controller that drives it, then waits until every lane reports that it is parked in stop state. A start request releases the controller reset and turns on the PHY enable-clock while the PHY's shutdown_n and reset_n stay low. Test-clear is then pulsed, and the sequencer asks an external configuration step (PLL and lane timing programming) to run through a req/ack handshake. When the ack arrives, shutdown_n and then reset_n are raised, each after a guard delay.

After reset_n is released, the sequencer checks the synchronised stop-state flags of the clock lane and all data lanes at a fixed interval. It flags done on the first check that finds all of them set. If a bounded number of checks all fail, it flags timeout instead. A stop request aborts from any state and parks the PHY: reset_n and shutdown_n go low and test-clear goes high. The lane-enable field handed to the PHY is the requested lane count minus one, clamped to the legal range. The high-speed clock request is passed through only while the link is up.

Top module: `phy_pwrup_seq`

## Requirements
- R1: During and right after reset: ctrl_rst_n_o, phy_enclk_o, phy_shutdown_n_o, phy_rst_n_o, cfg_req_o, done_o, timeout_o and hs_clk_req_o are 0, lane_en_o is 0 and test_clr_o is 1.
- R2: A start request taken while idle, done or timed out sets ctrl_rst_n_o and phy_enclk_o to 1 while phy_shutdown_n_o and phy_rst_n_o stay 0. It then holds test_clr_o high for CLR_CYC cycles before driving it low.
- R3: cfg_req_o rises GUARD_CYC cycles after test_clr_o falls and stays high until a cycle with cfg_ack_i high. While cfg_req_o is high, test_clr_o and phy_shutdown_n_o are 0.
- R4: lane_en_o is loaded when the configuration request is raised. Its value is 0 for a lane count of 0, NUM_DATA-1 for a count above NUM_DATA, and count-1 otherwise.
- R5: cfg_req_o falls in the cycle after the ack. phy_shutdown_n_o rises GUARD_CYC cycles later, and phy_rst_n_o rises GUARD_CYC cycles after that. phy_rst_n_o is never high without phy_shutdown_n_o, and phy_shutdown_n_o is never high without phy_enclk_o.
- R6: done_o is raised only by a check that finds the clock-lane flag and all NUM_DATA data-lane flags set together. With all flags steady high, done_o rises GUARD_CYC + POLL_CYC cycles after phy_rst_n_o.
- R7: If any flag stays low, timeout_o rises GUARD_CYC + MAX_POLLS*POLL_CYC cycles after phy_rst_n_o and done_o stays 0. done_o and timeout_o are never high together.
- R8: A start request arriving while a sequence is in progress has no effect: an ongoing configuration request stays high and test_clr_o stays low.
- R9: A stop request, from any state, makes phy_rst_n_o, phy_shutdown_n_o, cfg_req_o, done_o and timeout_o 0 and test_clr_o 1 in the next cycle. Stop wins over a simultaneous start.
- R10: hs_clk_req_o follows hs_clk_want_i only while done_o is high and is 0 otherwise.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| start_i | input | 1 | Start the power-up sequence |
| stop_i | input | 1 | Abort and park the PHY |
| lane_cnt_i | input | LANE_W+1 | Number of data lanes requested |
| stop_clk_i | input | 1 | Clock-lane stop-state flag |
| stop_data_i | input | NUM_DATA | Data-lane stop-state flags |
| cfg_ack_i | input | 1 | External configuration finished |
| hs_clk_want_i | input | 1 | Controller wants continuous high-speed clock |
| cfg_req_o | output | 1 | Request to run the external configuration |
| ctrl_rst_n_o | output | 1 | Controller reset, active low |
| phy_enclk_o | output | 1 | PHY enable-clock |
| phy_shutdown_n_o | output | 1 | PHY shutdown, active low |
| phy_rst_n_o | output | 1 | PHY reset, active low |
| test_clr_o | output | 1 | PHY test-clear |
| lane_en_o | output | LANE_W | Lane-enable field (lanes minus one) |
| hs_clk_req_o | output | 1 | Gated continuous high-speed clock request |
| done_o | output | 1 | All lanes reached stop state |
| timeout_o | output | 1 | Stop state not reached within the retry limit |

## Verification
The sequence runs once for every one of the 32 combinations of the five stop-state flags. This shows that only the all-set pattern ends in done and that each single missing lane, clock lane included, leads to timeout after exactly the retry limit. The lane count cycles through every encodable value across these runs, which covers both clamp edges of the lane-enable field. The ack delay is varied so the hold of the configuration request is seen with different waits. Separate runs abort in the middle of configuration and of polling, with stop and start raised together, to tell an aborted sequence from a restarted one.

// File: rtl/phy_seq_pkg.sv
package phy_seq_pkg;

  typedef enum logic [3:0] {
    ST_IDLE,
    ST_CLR_HI,
    ST_CLR_LO,
    ST_CFG,
    ST_EN_CLK,
    ST_SHUT,
    ST_RST,
    ST_POLL,
    ST_DONE,
    ST_TMO
  } seq_state_e;

endpackage

// File: rtl/phy_seq_timer.sv
// Loadable down-counter used for guard delays and the poll interval.
module phy_seq_timer #(
  parameter int W = 4
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         load_i,
  input  logic [W-1:0] val_i,
  output logic         zero_o
);

  logic [W-1:0] cnt;

  always_ff @(posedge clk) begin
    if (rst) begin
      cnt <= '0;
    end else if (load_i) begin
      cnt <= val_i;
    end else if (cnt != '0) begin
      cnt <= cnt - 1'b1;
    end
  end

  assign zero_o = (cnt == '0);

endmodule

// File: rtl/phy_seq_stopsync.sv
// Synchroniser chain for the lane stop-state flags, plus all-set reduction.
module phy_seq_stopsync #(
  parameter int LANES  = 5,
  parameter int STAGES = 2
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [LANES-1:0] flags_i,
  output logic             all_o
);

  logic [LANES-1:0] pipe [STAGES];

  for (genvar g = 0; g < STAGES; g++) begin : g_stage
    if (g == 0) begin : g_first
      always_ff @(posedge clk) begin
        if (rst) pipe[g] <= '0;
        else     pipe[g] <= flags_i;
      end
    end else begin : g_next
      always_ff @(posedge clk) begin
        if (rst) pipe[g] <= '0;
        else     pipe[g] <= pipe[g-1];
      end
    end
  end

  assign all_o = &pipe[STAGES-1];

endmodule

// File: rtl/phy_seq_lanefield.sv
// Lane count to lane-enable field (count minus one), clamped to range.
module phy_seq_lanefield #(
  parameter int NUM_DATA = 4,
  localparam int LW = (NUM_DATA > 1) ? $clog2(NUM_DATA) : 1
) (
  input  logic [LW:0]   cnt_i,
  output logic [LW-1:0] field_o
);

  always_comb begin
    if (cnt_i == '0) begin
      field_o = '0;
    end else if (int'(cnt_i) > NUM_DATA) begin
      field_o = LW'(NUM_DATA - 1);
    end else begin
      field_o = LW'(cnt_i - (LW+1)'(1));
    end
  end

endmodule

// File: rtl/phy_pwrup_seq.sv
module phy_pwrup_seq
  import phy_seq_pkg::*;
#(
  parameter int NUM_DATA    = 4,
  parameter int CLR_CYC     = 2,
  parameter int GUARD_CYC   = 3,
  parameter int POLL_CYC    = 4,
  parameter int MAX_POLLS   = 30,
  parameter int SYNC_STAGES = 2,
  localparam int LANE_W = (NUM_DATA > 1) ? $clog2(NUM_DATA) : 1
) (
  input  logic                clk,
  input  logic                rst,
  input  logic                start_i,
  input  logic                stop_i,
  input  logic [LANE_W:0]     lane_cnt_i,
  input  logic                stop_clk_i,
  input  logic [NUM_DATA-1:0] stop_data_i,
  input  logic                cfg_ack_i,
  input  logic                hs_clk_want_i,
  output logic                cfg_req_o,
  output logic                ctrl_rst_n_o,
  output logic                phy_enclk_o,
  output logic                phy_shutdown_n_o,
  output logic                phy_rst_n_o,
  output logic                test_clr_o,
  output logic [LANE_W-1:0]   lane_en_o,
  output logic                hs_clk_req_o,
  output logic                done_o,
  output logic                timeout_o
);

  localparam int TMAX0 = (CLR_CYC > GUARD_CYC) ? CLR_CYC : GUARD_CYC;
  localparam int TMAX  = (TMAX0 > POLL_CYC) ? TMAX0 : POLL_CYC;
  localparam int TW    = $clog2(TMAX + 1);
  localparam int PCW   = $clog2(MAX_POLLS + 1);
  localparam logic [PCW-1:0] POLL_LAST = PCW'(MAX_POLLS - 1);

  seq_state_e state, state_n;
  logic [TW-1:0]     tmr_val;
  logic              tmr_load, tmr_zero;
  logic [PCW-1:0]    poll_cnt;
  logic              all_stop;
  logic [LANE_W-1:0] lane_fld;

  phy_seq_timer #(.W(TW)) u_timer (
    .clk    (clk),
    .rst    (rst),
    .load_i (tmr_load),
    .val_i  (tmr_val),
    .zero_o (tmr_zero)
  );

  phy_seq_stopsync #(.LANES(NUM_DATA + 1), .STAGES(SYNC_STAGES)) u_sync (
    .clk     (clk),
    .rst     (rst),
    .flags_i ({stop_data_i, stop_clk_i}),
    .all_o   (all_stop)
  );

  phy_seq_lanefield #(.NUM_DATA(NUM_DATA)) u_lane (
    .cnt_i   (lane_cnt_i),
    .field_o (lane_fld)
  );

  // Next-state logic; stop has priority over everything.
  always_comb begin
    state_n = state;
    if (stop_i) begin
      state_n = ST_IDLE;
    end else begin
      unique case (state)
        ST_IDLE, ST_DONE, ST_TMO: if (start_i) state_n = ST_CLR_HI;
        ST_CLR_HI: if (tmr_zero) state_n = ST_CLR_LO;
        ST_CLR_LO: if (tmr_zero) state_n = ST_CFG;
        ST_CFG:    if (cfg_ack_i) state_n = ST_EN_CLK;
        ST_EN_CLK: if (tmr_zero) state_n = ST_SHUT;
        ST_SHUT:   if (tmr_zero) state_n = ST_RST;
        ST_RST:    if (tmr_zero) state_n = ST_POLL;
        ST_POLL: begin
          if (tmr_zero) begin
            if (all_stop)                  state_n = ST_DONE;
            else if (poll_cnt == POLL_LAST) state_n = ST_TMO;
          end
        end
        default: state_n = ST_IDLE;
      endcase
    end
  end

  // Timer reload value for the state being entered.
  always_comb begin
    unique case (state_n)
      ST_CLR_HI:                   tmr_val = TW'(CLR_CYC - 1);
      ST_CLR_LO, ST_EN_CLK,
      ST_SHUT, ST_RST:             tmr_val = TW'(GUARD_CYC - 1);
      ST_POLL:                     tmr_val = TW'(POLL_CYC - 1);
      default:                     tmr_val = '0;
    endcase
  end

  assign tmr_load = (state_n != state) || ((state == ST_POLL) && tmr_zero);

  always_ff @(posedge clk) begin
    if (rst || state != ST_POLL) begin
      poll_cnt <= '0;
    end else if (tmr_zero) begin
      poll_cnt <= poll_cnt + 1'b1;
    end
  end

  // State and registered outputs, decoded from the next state.
  always_ff @(posedge clk) begin
    if (rst) begin
      state            <= ST_IDLE;
      ctrl_rst_n_o     <= 1'b0;
      phy_enclk_o      <= 1'b0;
      phy_shutdown_n_o <= 1'b0;
      phy_rst_n_o      <= 1'b0;
      test_clr_o       <= 1'b1;
      cfg_req_o        <= 1'b0;
      lane_en_o        <= '0;
      hs_clk_req_o     <= 1'b0;
      done_o           <= 1'b0;
      timeout_o        <= 1'b0;
    end else begin
      state <= state_n;
      if (state_n == ST_CLR_HI) begin
        ctrl_rst_n_o <= 1'b1;
        phy_enclk_o  <= 1'b1;
      end
      phy_shutdown_n_o <= (state_n == ST_SHUT) || (state_n == ST_RST) ||
                          (state_n == ST_POLL) || (state_n == ST_DONE) ||
                          (state_n == ST_TMO);
      phy_rst_n_o      <= (state_n == ST_RST) || (state_n == ST_POLL) ||
                          (state_n == ST_DONE) || (state_n == ST_TMO);
      test_clr_o       <= (state_n == ST_IDLE) || (state_n == ST_CLR_HI);
      cfg_req_o        <= (state_n == ST_CFG);
      if ((state_n == ST_CFG) && (state != ST_CFG)) begin
        lane_en_o <= lane_fld;
      end
      hs_clk_req_o     <= (state_n == ST_DONE) && hs_clk_want_i;
      done_o           <= (state_n == ST_DONE);
      timeout_o        <= (state_n == ST_TMO);
    end
  end

endmodule

// File: rtl/phy_pwrup_seq_chk.sv
module phy_pwrup_seq_chk (
  input logic clk,
  input logic rst,
  input logic stop_i,
  input logic cfg_ack_i,
  input logic cfg_req_o,
  input logic ctrl_rst_n_o,
  input logic phy_enclk_o,
  input logic phy_shutdown_n_o,
  input logic phy_rst_n_o,
  input logic test_clr_o,
  input logic hs_clk_req_o,
  input logic done_o,
  input logic timeout_o
);

  assert_clr_R3: assert property (@(posedge clk) disable iff (rst)
    cfg_req_o |-> (!test_clr_o && !phy_shutdown_n_o && ctrl_rst_n_o));

  assert_hold_R3: assert property (@(posedge clk) disable iff (rst)
    (cfg_req_o && !cfg_ack_i && !stop_i) |=> cfg_req_o);

  assert_rst_order_R5: assert property (@(posedge clk) disable iff (rst)
    phy_rst_n_o |-> phy_shutdown_n_o);

  assert_shut_order_R5: assert property (@(posedge clk) disable iff (rst)
    phy_shutdown_n_o |-> phy_enclk_o);

  assert_done_up_R6: assert property (@(posedge clk) disable iff (rst)
    done_o |-> (phy_rst_n_o && !cfg_req_o));

  assert_excl_R7: assert property (@(posedge clk) disable iff (rst)
    !(done_o && timeout_o));

  assert_stop_R9: assert property (@(posedge clk) disable iff (rst)
    stop_i |=> (!phy_rst_n_o && !phy_shutdown_n_o && test_clr_o &&
                !cfg_req_o && !done_o && !timeout_o));

  assert_hs_R10: assert property (@(posedge clk) disable iff (rst)
    hs_clk_req_o |-> done_o);

endmodule

bind phy_pwrup_seq phy_pwrup_seq_chk u_chk (
  .clk              (clk),
  .rst              (rst),
  .stop_i           (stop_i),
  .cfg_ack_i        (cfg_ack_i),
  .cfg_req_o        (cfg_req_o),
  .ctrl_rst_n_o     (ctrl_rst_n_o),
  .phy_enclk_o      (phy_enclk_o),
  .phy_shutdown_n_o (phy_shutdown_n_o),
  .phy_rst_n_o      (phy_rst_n_o),
  .test_clr_o       (test_clr_o),
  .hs_clk_req_o     (hs_clk_req_o),
  .done_o           (done_o),
  .timeout_o        (timeout_o)
);

// File: tb/phy_pwrup_seq_test.sv
`timescale 1ns/1ps
module phy_pwrup_seq_test;

  localparam int ND     = 4;
  localparam int LW     = 2;
  localparam int CLRC   = 2;
  localparam int GUARD  = 3;
  localparam int POLL   = 4;
  localparam int MAXP   = 30;
  localparam int WDOG   = 150000;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic start_i = 1'b0, stop_i = 1'b0, cfg_ack_i = 1'b0, hs_clk_want_i = 1'b0;
  logic [LW:0] lane_cnt_i = '0;
  logic stop_clk_i = 1'b0;
  logic [ND-1:0] stop_data_i = '0;
  logic cfg_req_o, ctrl_rst_n_o, phy_enclk_o, phy_shutdown_n_o, phy_rst_n_o;
  logic test_clr_o, hs_clk_req_o, done_o, timeout_o;
  logic [LW-1:0] lane_en_o;

  int n_cmp = 0;
  int n_bad = 0;
  int cycles = 0;

  phy_pwrup_seq #(
    .NUM_DATA(ND), .CLR_CYC(CLRC), .GUARD_CYC(GUARD),
    .POLL_CYC(POLL), .MAX_POLLS(MAXP), .SYNC_STAGES(2)
  ) uut (
    .clk(clk), .rst(rst), .start_i(start_i), .stop_i(stop_i),
    .lane_cnt_i(lane_cnt_i), .stop_clk_i(stop_clk_i), .stop_data_i(stop_data_i),
    .cfg_ack_i(cfg_ack_i), .hs_clk_want_i(hs_clk_want_i),
    .cfg_req_o(cfg_req_o), .ctrl_rst_n_o(ctrl_rst_n_o), .phy_enclk_o(phy_enclk_o),
    .phy_shutdown_n_o(phy_shutdown_n_o), .phy_rst_n_o(phy_rst_n_o),
    .test_clr_o(test_clr_o), .lane_en_o(lane_en_o), .hs_clk_req_o(hs_clk_req_o),
    .done_o(done_o), .timeout_o(timeout_o)
  );

  always #10 clk = ~clk;

  always @(posedge clk) begin
    cycles <= cycles + 1;
    if (cycles == WDOG) begin
      n_cmp = n_cmp + 1;
      n_bad = n_bad + 1;
      $display("FAIL watchdog actual=%0d expected<%0d", cycles, WDOG);
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
    end
  end

  task automatic check(input bit ok, input string req, input int act, input int exp);
    n_cmp++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  function automatic int lane_exp(input int c);
    if (c == 0) return 0;
    if (c > ND) return ND - 1;
    return c - 1;
  endfunction

  // Outputs packed for reporting: {rst_n, shutdown_n, test_clr, cfg_req, done, timeout}
  function automatic int park_bits();
    return {26'd0, phy_rst_n_o, phy_shutdown_n_o, test_clr_o, cfg_req_o, done_o, timeout_o};
  endfunction

  task automatic do_stop(input bit with_start);
    @(negedge clk);
    stop_i = 1'b1;
    start_i = with_start;
    @(negedge clk);
    stop_i = 1'b0;
    start_i = 1'b0;
    // R9: parked state: only test_clr high among these
    check(park_bits() == 6'b001000, "R9 stop parks PHY", park_bits(), 6'b001000);
  endtask

  task automatic start_to_cfg(input int lanes);
    int n;
    start_i = 1'b1;
    @(negedge clk);
    start_i = 1'b0;
    check(ctrl_rst_n_o && phy_enclk_o && !phy_rst_n_o && !phy_shutdown_n_o && test_clr_o,
          "R2 start outputs", {ctrl_rst_n_o, phy_enclk_o, phy_shutdown_n_o, phy_rst_n_o, test_clr_o},
          5'b11001);
    n = 0;
    while (test_clr_o && n < 100) begin n++; @(negedge clk); end
    check(n == CLRC, "R2 test-clear pulse length", n, CLRC);
    n = 0;
    while (!cfg_req_o && n < 100) begin n++; @(negedge clk); end
    check(n == GUARD, "R3 cfg request delay", n, GUARD);
    check(int'(lane_en_o) == lane_exp(lanes), "R4 lane field", lane_en_o, lane_exp(lanes));
    check(!hs_clk_req_o, "R10 hs req low while configuring", hs_clk_req_o, 0);
  endtask

  task automatic run_seq(input logic [ND:0] flags, input int lanes, input int ackdly);
    int n;
    bit all;
    all = &flags;
    do_stop(1'b0);
    stop_clk_i = flags[0];
    stop_data_i = flags[ND:1];
    lane_cnt_i = (LW+1)'(lanes);
    hs_clk_want_i = 1'b1;
    repeat (4) @(negedge clk);
    start_to_cfg(lanes);
    start_i = 1'b1;
    @(negedge clk);
    start_i = 1'b0;
    check(cfg_req_o && !test_clr_o, "R8 start ignored while running",
          {cfg_req_o, test_clr_o}, 2'b10);
    repeat (ackdly) @(negedge clk);
    check(cfg_req_o, "R3 cfg request held until ack", cfg_req_o, 1);
    cfg_ack_i = 1'b1;
    @(negedge clk);
    cfg_ack_i = 1'b0;
    check(!cfg_req_o && !phy_shutdown_n_o, "R5 request drops after ack",
          {cfg_req_o, phy_shutdown_n_o}, 0);
    n = 0;
    while (!phy_shutdown_n_o && n < 100) begin n++; @(negedge clk); end
    check(n == GUARD, "R5 shutdown_n guard", n, GUARD);
    n = 0;
    while (!phy_rst_n_o && n < 100) begin n++; @(negedge clk); end
    check(n == GUARD, "R5 reset_n guard", n, GUARD);
    n = 0;
    while (!done_o && !timeout_o && n < 1000) begin n++; @(negedge clk); end
    if (all) begin
      check(n == GUARD + POLL, "R6 done latency", n, GUARD + POLL);
      check(done_o && !timeout_o, "R6 done flagged", {done_o, timeout_o}, 2'b10);
      check(hs_clk_req_o, "R10 hs req passes when done", hs_clk_req_o, 1);
      hs_clk_want_i = 1'b0;
      @(negedge clk);
      check(!hs_clk_req_o, "R10 hs req follows want", hs_clk_req_o, 0);
    end else begin
      check(n == GUARD + MAXP * POLL, "R7 timeout latency", n, GUARD + MAXP * POLL);
      check(timeout_o && !done_o, "R7 timeout flagged", {done_o, timeout_o}, 2'b01);
    end
  endtask

  initial begin
    repeat (3) @(negedge clk);
    // R1: reset values observed while reset is held
    check(park_bits() == 6'b001000 && !ctrl_rst_n_o && !phy_enclk_o && lane_en_o == '0 &&
          !hs_clk_req_o, "R1 reset values", park_bits(), 6'b001000);
    rst = 1'b0;
    @(negedge clk);
    check(park_bits() == 6'b001000 && !ctrl_rst_n_o && !phy_enclk_o,
          "R1 values after reset release", park_bits(), 6'b001000);

    // Full sweep over all stop-flag patterns, lane counts and ack delays.
    for (int i = 0; i < 32; i++) begin
      run_seq(5'(i), i % 8, (i % 3) + 1);
    end
    run_seq(5'h1F, 4, 2);
    run_seq(5'h1F, 0, 1);

    // R9: abort while configuration is pending.
    do_stop(1'b0);
    lane_cnt_i = 3'd2;
    stop_clk_i = 1'b0;
    stop_data_i = '0;
    repeat (2) @(negedge clk);
    start_to_cfg(2);
    do_stop(1'b0);
    repeat (5) @(negedge clk);
    check(!cfg_req_o && test_clr_o, "R9 abort from configuration stays parked",
          {cfg_req_o, test_clr_o}, 2'b01);

    // R9: abort while polling, with start raised in the same cycle.
    start_i = 1'b1;
    @(negedge clk);
    start_i = 1'b0;
    begin
      int n;
      n = 0;
      while (!cfg_req_o && n < 100) begin n++; @(negedge clk); end
    end
    cfg_ack_i = 1'b1;
    @(negedge clk);
    cfg_ack_i = 1'b0;
    begin
      int n;
      n = 0;
      while (!phy_rst_n_o && n < 100) begin n++; @(negedge clk); end
    end
    repeat (7) @(negedge clk);
    do_stop(1'b1);
    repeat (CLRC + GUARD + 3) @(negedge clk);
    check(park_bits() == 6'b001000, "R9 stop wins over start", park_bits(), 6'b001000);

    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

endmodule